// File: doc/BRIEF.md
# Variable-Rate Bit Shifter with Frame Marker Sync

This block sits behind a bit-recovery front end that samples an incoming serial line several times per bit. That front end follows the drift between the transmitter and receiver clocks, so in any receive clock cycle it delivers no new bit, one new bit, or two new bits. The block takes those bits in arrival order and runs a bit-serial framing engine over them. The engine first searches the stream for a marker pattern set at compile time. Once the marker has been found, it collects a fixed number of payload bits and presents them as one word.

No long training sequence is needed. A short idle preamble that toggles the line is enough for the front end to settle. The first complete marker then locks the framing. After each word, the search starts again on the bits that follow. The default marker is a single one followed by thirteen zeros, and the default payload is ten bits.

The word output is a one-cycle strobe with no back-pressure: the downstream consumer must take `word_data` in the cycle in which `word_valid` is high, because the line cannot be paused. `word_data` keeps its value until the next word completes.

Top module: `vrs_frame_rx`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `word_valid` is 0, `frame_locked` is 0 and `word_data` is all zeros.
- R2: A `shift_code` of 0 or 3 consumes no bit. A hold cycle placed anywhere in the stream, whether inside the marker or inside the payload, changes neither the words produced nor their contents. The cycle after a hold never shows a `word_valid` pulse.
- R3: A `shift_code` of 1 consumes `bit_lo` only. A `shift_code` of 2 consumes `bit_hi` first, as the older bit, and then `bit_lo`.
- R4: The marker `MARK` (MSB compared against the oldest of `MARK_LEN` bits) is checked after every consumed bit, including either of the two bits of a code-2 cycle. A match needs `MARK_LEN` bits consumed since reset or since the last completed word.
- R5: The `PAY_W` bits that follow a marker form one word, with the first bit in the MSB. `word_valid` is high for exactly one cycle, starting in the cycle after the clock edge that consumed the last payload bit. `word_data` holds the word until the next one completes.
- R6: `frame_locked` rises in the cycle after the first marker match and stays high until reset. `word_valid` is never high while `frame_locked` is low.
- R7: After a word completes, the marker search resumes at once. The second bit of the same code-2 cycle already counts toward the next marker, so frames sent back to back are all received.
- R8: A stream made of a short idle preamble with 0-to-1 transitions, then a marker, then a payload produces the correct word, with no training sequence needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_hi | input | 1 | Older recovered bit, used when `shift_code` is 2 |
| bit_lo | input | 1 | Newer recovered bit, used when `shift_code` is 1 or 2 |
| shift_code | input | 2 | Bits delivered this cycle: 0 = none, 1 = one, 2 = two, 3 = none |
| word_data | output | PAY_W | Last completed payload word, first bit in the MSB |
| word_valid | output | 1 | One-cycle strobe marking a new word |
| frame_locked | output | 1 | High once a marker has been found since reset |

## Verification
The bench feeds the same kind of framed stream in four patterns, each of which isolates one property:
- Single-bit delivery only: this shows that framing and word assembly work in the simplest case.
- Double-bit delivery with the marker at an odd bit offset: this shows that the two bits of a cycle are consumed in the right order and that a match is found at either lane position.
- Streams with hold codes 0 and 3 scattered inside markers and payloads: these must give the same words as the same streams without holds.
- Back-to-back frames whose last payload bit shares a cycle with the next marker's first bit: this shows that the search re-arms immediately.

Constrained-random streams, with random idle gaps, random payloads and mixed shift codes, are then checked every cycle against a bit-serial reference model in the bench.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  // Framing engine mode: hunting for the marker or collecting payload bits.
  typedef enum logic {
    MODE_HUNT = 1'b0,
    MODE_PAY  = 1'b1
  } mode_e;

  // Shift code values delivered by the bit-recovery front end.
  localparam logic [1:0] SH_HOLD  = 2'd0;
  localparam logic [1:0] SH_ONE   = 2'd1;
  localparam logic [1:0] SH_TWO   = 2'd2;
  localparam logic [1:0] SH_RSVD  = 2'd3;
endpackage

// File: rtl/vrs_lane_map.sv
// Maps the shift code onto two ordered bit lanes.
// Lane 0 carries the older bit (bit_hi) and is used only on a two-bit cycle.
// Lane 1 carries bit_lo on both one-bit and two-bit cycles.
module vrs_lane_map (
  input  logic [1:0] shift_code,
  input  logic       bit_hi,
  input  logic       bit_lo,
  output logic [1:0] lane_en,
  output logic [1:0] lane_bit
);
  always_comb begin
    lane_en[0]  = (shift_code == vrs_pkg::SH_TWO);
    lane_en[1]  = (shift_code == vrs_pkg::SH_ONE) || (shift_code == vrs_pkg::SH_TWO);
    lane_bit[0] = bit_hi;
    lane_bit[1] = bit_lo;
  end
endmodule

// File: rtl/vrs_bit_step.sv
// One bit's worth of framing: advances the engine state by a single bit.
module vrs_bit_step #(
  parameter int                 MARK_LEN = 14,
  parameter int                 PAY_W    = 10,
  parameter logic [MARK_LEN-1:0] MARK    = 14'b10000000000000,
  localparam int                FW       = $clog2(MARK_LEN + 1),
  localparam int                CW       = $clog2(PAY_W + 1)
) (
  input  logic                  en_i,
  input  logic                  bit_i,
  input  vrs_pkg::mode_e        mode_i,
  input  logic [MARK_LEN-1:0]   hist_i,
  input  logic [FW-1:0]         fill_i,
  input  logic [CW-1:0]         pcnt_i,
  input  logic [PAY_W-1:0]      word_i,
  output vrs_pkg::mode_e        mode_o,
  output logic [MARK_LEN-1:0]   hist_o,
  output logic [FW-1:0]         fill_o,
  output logic [CW-1:0]         pcnt_o,
  output logic [PAY_W-1:0]      word_o,
  output logic                  hit_o,
  output logic                  emit_o
);
  localparam logic [FW-1:0] FILL_FULL = FW'(MARK_LEN);
  localparam logic [CW-1:0] PAY_LAST  = CW'(PAY_W);

  logic [MARK_LEN-1:0] hist_sh;
  logic [FW-1:0]       fill_inc;
  logic [CW-1:0]       pcnt_inc;

  always_comb begin
    hist_sh  = {hist_i[MARK_LEN-2:0], bit_i};
    fill_inc = (fill_i == FILL_FULL) ? fill_i : fill_i + 1'b1;
    pcnt_inc = pcnt_i + 1'b1;

    mode_o = mode_i;
    hist_o = hist_i;
    fill_o = fill_i;
    pcnt_o = pcnt_i;
    word_o = word_i;
    hit_o  = 1'b0;
    emit_o = 1'b0;

    if (en_i) begin
      if (mode_i == vrs_pkg::MODE_HUNT) begin
        hist_o = hist_sh;
        fill_o = fill_inc;
        if ((fill_inc == FILL_FULL) && (hist_sh == MARK)) begin
          hit_o  = 1'b1;
          mode_o = vrs_pkg::MODE_PAY;
          pcnt_o = '0;
          fill_o = '0;
        end
      end else begin
        word_o = {word_i[PAY_W-2:0], bit_i};
        pcnt_o = pcnt_inc;
        if (pcnt_inc == PAY_LAST) begin
          emit_o = 1'b1;
          mode_o = vrs_pkg::MODE_HUNT;
          pcnt_o = '0;
          hist_o = '0;
          fill_o = '0;
        end
      end
    end
  end
endmodule

// File: rtl/vrs_frame_rx.sv
// Variable-rate shifter with marker-based framing.
// MARK_LEN >= 2 and PAY_W >= 3 are expected.
module vrs_frame_rx #(
  parameter int                  MARK_LEN = 14,
  parameter int                  PAY_W    = 10,
  parameter logic [MARK_LEN-1:0] MARK     = 14'b10000000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_hi,
  input  logic             bit_lo,
  input  logic [1:0]       shift_code,
  output logic [PAY_W-1:0] word_data,
  output logic             word_valid,
  output logic             frame_locked
);
  localparam int LANES = 2;
  localparam int FW    = $clog2(MARK_LEN + 1);
  localparam int CW    = $clog2(PAY_W + 1);

  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] lane_bit;
  logic [LANES-1:0] lane_hit;
  logic [LANES-1:0] lane_emit;

  // Chain of engine states; index 0 is the registered state.
  vrs_pkg::mode_e      mode_c [LANES+1];
  logic [MARK_LEN-1:0] hist_c [LANES+1];
  logic [FW-1:0]       fill_c [LANES+1];
  logic [CW-1:0]       pcnt_c [LANES+1];
  logic [PAY_W-1:0]    word_c [LANES+1];

  vrs_lane_map u_map (
    .shift_code (shift_code),
    .bit_hi     (bit_hi),
    .bit_lo     (bit_lo),
    .lane_en    (lane_en),
    .lane_bit   (lane_bit)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vrs_bit_step #(
      .MARK_LEN (MARK_LEN),
      .PAY_W    (PAY_W),
      .MARK     (MARK)
    ) u_step (
      .en_i   (lane_en[g]),
      .bit_i  (lane_bit[g]),
      .mode_i (mode_c[g]),
      .hist_i (hist_c[g]),
      .fill_i (fill_c[g]),
      .pcnt_i (pcnt_c[g]),
      .word_i (word_c[g]),
      .mode_o (mode_c[g+1]),
      .hist_o (hist_c[g+1]),
      .fill_o (fill_c[g+1]),
      .pcnt_o (pcnt_c[g+1]),
      .word_o (word_c[g+1]),
      .hit_o  (lane_hit[g]),
      .emit_o (lane_emit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_c[0]    <= vrs_pkg::MODE_HUNT;
      hist_c[0]    <= '0;
      fill_c[0]    <= '0;
      pcnt_c[0]    <= '0;
      word_c[0]    <= '0;
      word_data    <= '0;
      word_valid   <= 1'b0;
      frame_locked <= 1'b0;
    end else begin
      mode_c[0]    <= mode_c[LANES];
      hist_c[0]    <= hist_c[LANES];
      fill_c[0]    <= fill_c[LANES];
      pcnt_c[0]    <= pcnt_c[LANES];
      word_c[0]    <= word_c[LANES];
      word_valid   <= |lane_emit;
      frame_locked <= frame_locked | (|lane_hit);
      if (|lane_emit) begin
        word_data <= word_c[LANES];
      end
    end
  end
endmodule

// File: rtl/vrs_frame_rx_chk.sv
module vrs_frame_rx_chk #(
  parameter int PAY_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       shift_code,
  input logic [PAY_W-1:0] word_data,
  input logic             word_valid,
  input logic             frame_locked
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);                                          // R5
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_data));                                  // R5
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_code == 2'd0 || shift_code == 2'd3) |=> !word_valid);          // R2
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_locked |=> frame_locked);                                       // R6
  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> frame_locked);                                         // R6
endmodule

bind vrs_frame_rx vrs_frame_rx_chk #(.PAY_W(PAY_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .shift_code   (shift_code),
  .word_data    (word_data),
  .word_valid   (word_valid),
  .frame_locked (frame_locked)
);

// File: tb/tb_vrs_frame_rx.sv
module tb_vrs_frame_rx;
  localparam int              CLK_PERIOD = 10;
  localparam int              ML   = 14;
  localparam int              PW   = 10;
  localparam logic [ML-1:0]   MARK = 14'b10000000000000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_hi = 1'b0, bit_lo = 1'b0;
  logic [1:0]    shift_code = 2'd0;
  logic [PW-1:0] word_data;
  logic          word_valid, frame_locked;

  always #(CLK_PERIOD/2) clk = ~clk;

  vrs_frame_rx #(.MARK_LEN(ML), .PAY_W(PW), .MARK(MARK)) dut (
    .clk(clk), .rst_n(rst_n), .bit_hi(bit_hi), .bit_lo(bit_lo),
    .shift_code(shift_code), .word_data(word_data),
    .word_valid(word_valid), .frame_locked(frame_locked)
  );

  int vectors = 0;
  int fails   = 0;
  int seen    = 0;
  string cur_tag = "R5";

  // Bit-serial reference model.
  logic          m_hunt = 1'b1;
  logic [ML-1:0] m_hist = '0;
  int            m_fill = 0;
  int            m_pcnt = 0;
  logic [PW-1:0] m_word = '0;
  logic [PW-1:0] m_last = '0;
  logic          m_locked = 1'b0;
  logic          m_emit = 1'b0;
  bit            q[$];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_bit(input logic b);
    if (m_hunt) begin
      m_hist = {m_hist[ML-2:0], b};
      if (m_fill < ML) m_fill++;
      if (m_fill == ML && m_hist == MARK) begin
        m_hunt = 1'b0; m_pcnt = 0; m_fill = 0; m_locked = 1'b1;
      end
    end else begin
      m_word = {m_word[PW-2:0], b};
      m_pcnt++;
      if (m_pcnt == PW) begin
        m_emit = 1'b1; m_last = m_word; m_hunt = 1'b1; m_fill = 0; m_hist = '0;
      end
    end
  endtask

  // One receive cycle: drive at the falling edge, check at the next one.
  task automatic cyc(input logic [1:0] code, input logic hi, input logic lo);
    shift_code = code; bit_hi = hi; bit_lo = lo;
    m_emit = 1'b0;
    if (code == 2'd2) begin model_bit(hi); model_bit(lo); end
    else if (code == 2'd1) model_bit(lo);
    @(negedge clk);
    chk(cur_tag, "word_valid", 32'(word_valid), 32'(m_emit));
    chk(cur_tag, "word_data", 32'(word_data), 32'(m_last));
    chk("R6", "frame_locked", 32'(frame_locked), 32'(m_locked));
    if (word_valid) seen++;
  endtask

  task automatic push_marker();
    for (int i = ML-1; i >= 0; i--) q.push_back(MARK[i]);
  endtask

  task automatic push_word(input logic [PW-1:0] w);
    for (int i = PW-1; i >= 0; i--) q.push_back(w[i]);
  endtask

  // mode 0: one bit per cycle; 1: two bits when possible; 2: random with holds
  task automatic feed(input int mode);
    while (q.size() > 0) begin
      int r;
      r = (mode == 2) ? int'($urandom % 5) : (mode == 1 ? 4 : 2);
      if (r == 0) cyc(2'd0, 1'($urandom), 1'($urandom));
      else if (r == 1) cyc(2'd3, 1'($urandom), 1'($urandom));
      else if (r == 2 || q.size() == 1) cyc(2'd1, 1'($urandom), q.pop_front());
      else begin
        bit a, b;
        a = q.pop_front(); b = q.pop_front();
        cyc(2'd2, a, b);
      end
    end
    cyc(2'd0, 1'b0, 1'b0);
  endtask

  task automatic preamble(input int n);
    for (int i = 0; i < n; i++) q.push_back(i[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "word_valid", 32'(word_valid), 0);
    chk("R1", "frame_locked", 32'(frame_locked), 0);
    chk("R1", "word_data", 32'(word_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "frame_locked after release", 32'(frame_locked), 0);

    // R8: short toggling preamble then one frame, single-bit delivery
    cur_tag = "R8";
    seen = 0;
    preamble(4); push_marker(); push_word(10'h2B5);
    feed(0);
    chk("R8", "words seen", 32'(seen), 1);
    chk("R8", "word", 32'(word_data), 32'h2B5);

    // R3/R4: two-bit delivery, marker at odd offset so it ends in lane 0
    cur_tag = "R3";
    seen = 0;
    preamble(3); push_marker(); push_word(10'h1C6);
    feed(1);
    chk("R4", "words seen odd offset", 32'(seen), 1);
    chk("R3", "bit order word", 32'(word_data), 32'h1C6);
    seen = 0;
    preamble(2); push_marker(); push_word(10'h0F3);
    feed(1);
    chk("R4", "words seen even offset", 32'(seen), 1);

    // R2: holds scattered through marker and payload
    cur_tag = "R2";
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      preamble(3 + k); push_marker(); push_word(10'(k * 97 + 5));
      feed(2);
    end
    chk("R2", "words seen with holds", 32'(seen), 4);

    // R7: back-to-back frames, last payload bit shares a cycle with next marker
    cur_tag = "R7";
    seen = 0;
    preamble(1); push_marker(); push_word(10'h3A1);
    push_marker(); push_word(10'h155);
    push_marker(); push_word(10'h2AA);
    feed(1);
    chk("R7", "back-to-back words", 32'(seen), 3);
    chk("R7", "last word", 32'(word_data), 32'h2AA);

    // R5: constrained-random framed streams
    cur_tag = "R5";
    for (int f = 0; f < 80; f++) begin
      int gap;
      gap = int'($urandom % 20);
      for (int i = 0; i < gap; i++) q.push_back(1'($urandom));
      push_marker();
      push_word(10'($urandom));
      feed(2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule